// File: doc/BRIEF.md
# Timer Event Flag and Capture Unit

This block surrounds a 16-bit free-running counter with the logic that records timer events. The events come from four input-capture channels, two compare registers and the counter's wrap from all ones to zero. Each event sets a sticky flag in an 8-bit status/control word. The same word carries one control bit: when it is set, the counter returns to zero after it matches compare register A. A small synchronous CPU port reads and writes the counter, the compare registers, the capture registers and the status word. The port uses a 3-bit address and 16-bit data. The overflow flag drives an interrupt request, which an enable input can mask.

Hardware alone raises the flags. To clear a flag, software must first read the status word while that flag shows 1, and then write 0 to that bit. A 0 written without that read is ignored. Capture channel A has an optional buffered mode. In that mode each new capture first pushes the previous A value into capture register C. The capture inputs are asynchronous. Each one passes through a synchronizer, and each rising edge produces exactly one capture.

Register addresses: 0 status/control (bits 7..0 in the low byte), 1 counter, 2 compare A, 3 compare B, 4 capture A, 5 capture B, 6 capture C, 7 capture D. Addresses 4 to 7 are read-only.

Top module: `tmr_evt_unit`

## Requirements
- R1: After reset, every addressable register reads 0 and the interrupt request is low.
- R2: Writing 1 to any of status bits 7..1 has no effect. Status bit 0 (clear-on-compare-A) reads back what was last written.
- R3: A flag is cleared by writing 0 to its bit only if the status word was read while that flag was 1, with no status write in between. A 0 written without that read leaves the flag set.
- R4: When a hardware set of a flag falls in the same cycle as a clearing write to that flag, the flag stays 1. Other armed flags in the same write still clear.
- R5: While the standby input is high, the whole status word, bit 0 included, is forced to 0x00 and all read-arming is dropped.
- R6: With buffered mode off, a rising edge on capture input A copies the counter into capture register A and sets status bit 7.
- R7: With buffered mode on, a rising edge on capture input A moves capture register A into capture register C and loads the counter into capture register A.
- R8: Capture inputs B, C and D load their own registers and set status bits 6, 5 and 4. In buffered mode, capture input C still sets bit 5 but does not load register C.
- R9: A capture input held high captures only once. It captures again only after it has gone low and risen again.
- R10: When the counter advances on a tick while equal to compare A (or compare B), status bit 3 (or bit 2) is set.
- R11: With status bit 0 set, a tick while the counter equals compare A loads zero instead of incrementing. With bit 0 clear, the counter runs freely.
- R12: A tick with the counter at 0xFFFF wraps it to 0x0000 and sets status bit 1.
- R13: The interrupt request is high exactly when status bit 1 is 1 and the overflow interrupt enable is 1.
- R14: The counter advances by one on each cycle with tick high. A CPU write to address 1 loads it and takes priority over the tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby_i | input | 1 | Standby: forces the status word to zero |
| tick_i | input | 1 | Counter advance enable (prescaled tick) |
| cap_i | input | 4 | Capture inputs, bit 0 = A, 1 = B, 2 = C, 3 = D |
| buf_a_i | input | 1 | Buffered mode for capture channel A |
| ovf_ie_i | input | 1 | Overflow interrupt enable |
| cpu_sel_i | input | 1 | Register access strobe |
| cpu_wr_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | 3 | Register address |
| cpu_wdata_i | input | 16 | Write data |
| cpu_rdata_o | output | 16 | Read data, valid in the cycle of the access |
| ovf_irq_o | output | 1 | Overflow interrupt request |

## Verification
The assertions check these behaviours on every cycle:
- Flags rise only from a hardware event in the previous cycle.
- A flag falls only after a status write or standby.
- Standby empties the status word.
- A synchronized capture event never lasts two cycles.
- A compare-A clear loads zero.
- The interrupt request follows the flag and the enable.

Only the bench's scenarios can show the rest:
- That a capture latches the correct counter value.
- How buffered mode moves data from A to C.
- The read-then-write ordering that clear needs, and set winning over clear in the same cycle.
- The cycle arithmetic of ticking, wrap and compare-clear.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;
   localparam int unsigned ADDR_W = 3;
   localparam int unsigned DATA_W = 16;

   localparam logic [ADDR_W-1:0] A_STS  = 3'd0;
   localparam logic [ADDR_W-1:0] A_CNT  = 3'd1;
   localparam logic [ADDR_W-1:0] A_CMPA = 3'd2;
   localparam logic [ADDR_W-1:0] A_CMPB = 3'd3;
   localparam logic [ADDR_W-1:0] A_CAPA = 3'd4;
   localparam logic [ADDR_W-1:0] A_CAPB = 3'd5;
   localparam logic [ADDR_W-1:0] A_CAPC = 3'd6;
   localparam logic [ADDR_W-1:0] A_CAPD = 3'd7;

   // status bit positions
   localparam int unsigned B_CAPA = 7;
   localparam int unsigned B_CAPB = 6;
   localparam int unsigned B_CAPC = 5;
   localparam int unsigned B_CAPD = 4;
   localparam int unsigned B_CMPA = 3;
   localparam int unsigned B_CMPB = 2;
   localparam int unsigned B_OVF  = 1;
   localparam int unsigned B_CCLR = 0;

   localparam int unsigned N_CAP = 4;

   typedef logic [7:1] flag_vec_t;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic pulse_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tmr_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], d_i};
         last_q <= sync_q[STAGES-1];
      end
   end

   assign pulse_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/tmr_free_counter.sv
module tmr_free_counter #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick_i,
   input  logic         ld_i,
   input  logic [W-1:0] ld_val_i,
   input  logic         clr_on_a_i,
   input  logic [W-1:0] cmp_a_i,
   input  logic [W-1:0] cmp_b_i,
   output logic [W-1:0] cnt_o,
   output logic         hit_a_o,
   output logic         hit_b_o,
   output logic         wrap_o
);
   localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
   localparam logic [W-1:0] CNT_ONE = {{(W-1){1'b0}}, 1'b1};

   logic [W-1:0] cnt_q;
   logic         step;

   assign step    = tick_i & ~ld_i;
   assign hit_a_o = step & (cnt_q == cmp_a_i);
   assign hit_b_o = step & (cnt_q == cmp_b_i);
   assign wrap_o  = step & (cnt_q == CNT_MAX) & ~(hit_a_o & clr_on_a_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (ld_i) begin
         cnt_q <= ld_val_i;
      end else if (step) begin
         if (hit_a_o && clr_on_a_i) cnt_q <= '0;
         else                       cnt_q <= cnt_q + CNT_ONE;
      end
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/tmr_status_reg.sv
module tmr_status_reg
   import tmr_evt_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      stby_i,
   input  flag_vec_t set_i,
   input  logic      rd_i,
   input  logic      wr_i,
   input  logic [7:0] wdata_i,
   output logic [7:0] sts_o
);
   flag_vec_t flag_q;
   flag_vec_t armed_q;
   logic      cclr_q;
   flag_vec_t clr_req;

   assign clr_req = {7{wr_i}} & armed_q & ~wdata_i[7:1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q  <= '0;
         armed_q <= '0;
         cclr_q  <= 1'b0;
      end else if (stby_i) begin
         flag_q  <= '0;
         armed_q <= '0;
         cclr_q  <= 1'b0;
      end else begin
         // a hardware set wins over a clear in the same cycle
         flag_q <= set_i | (flag_q & ~clr_req);
         if (rd_i)      armed_q <= flag_q;
         else if (wr_i) armed_q <= '0;
         if (wr_i)      cclr_q  <= wdata_i[B_CCLR];
      end
   end

   assign sts_o = {flag_q, cclr_q};
endmodule

// File: rtl/tmr_evt_unit.sv
module tmr_evt_unit
   import tmr_evt_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          BUF_A_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stby_i,
   input  logic              tick_i,
   input  logic [3:0]        cap_i,
   input  logic              buf_a_i,
   input  logic              ovf_ie_i,
   input  logic              cpu_sel_i,
   input  logic              cpu_wr_i,
   input  logic [2:0]        cpu_addr_i,
   input  logic [CNT_W-1:0]  cpu_wdata_i,
   output logic [CNT_W-1:0]  cpu_rdata_o,
   output logic              ovf_irq_o
);
   if (CNT_W != DATA_W) begin : g_bad_width
      $error("tmr_evt_unit: CNT_W must equal the port data width");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("tmr_evt_unit: SYNC_STAGES must be at least 2");
   end

   localparam int unsigned PAD_W = CNT_W - 8;

   logic [N_CAP-1:0] cap_evt;
   logic [CNT_W-1:0] cnt_q, cmp_a_q, cmp_b_q;
   logic [CNT_W-1:0] cap_a_q, cap_b_q, cap_c_q, cap_d_q;
   logic             hit_a, hit_b, wrap;
   logic [7:0]       sts_q;
   flag_vec_t        set_vec;
   logic             buf_on;
   logic             acc_wr, acc_rd;

   assign acc_wr = cpu_sel_i &  cpu_wr_i;
   assign acc_rd = cpu_sel_i & ~cpu_wr_i;

   for (genvar ch = 0; ch < N_CAP; ch++) begin : g_cap_sync
      tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk     (clk),
         .rst_n   (rst_n),
         .d_i     (cap_i[ch]),
         .pulse_o (cap_evt[ch])
      );
   end

   if (BUF_A_EN) begin : g_buf_a
      assign buf_on = buf_a_i;
   end else begin : g_no_buf_a
      assign buf_on = 1'b0;
   end

   tmr_free_counter #(.W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick_i),
      .ld_i       (acc_wr && cpu_addr_i == A_CNT),
      .ld_val_i   (cpu_wdata_i),
      .clr_on_a_i (sts_q[B_CCLR]),
      .cmp_a_i    (cmp_a_q),
      .cmp_b_i    (cmp_b_q),
      .cnt_o      (cnt_q),
      .hit_a_o    (hit_a),
      .hit_b_o    (hit_b),
      .wrap_o     (wrap)
   );

   assign set_vec = {cap_evt[0], cap_evt[1], cap_evt[2], cap_evt[3],
                     hit_a, hit_b, wrap};

   tmr_status_reg u_sts (
      .clk     (clk),
      .rst_n   (rst_n),
      .stby_i  (stby_i),
      .set_i   (set_vec),
      .rd_i    (acc_rd && cpu_addr_i == A_STS),
      .wr_i    (acc_wr && cpu_addr_i == A_STS),
      .wdata_i (cpu_wdata_i[7:0]),
      .sts_o   (sts_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_a_q <= '0;
         cmp_b_q <= '0;
      end else if (acc_wr) begin
         if (cpu_addr_i == A_CMPA) cmp_a_q <= cpu_wdata_i;
         if (cpu_addr_i == A_CMPB) cmp_b_q <= cpu_wdata_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_a_q <= '0;
         cap_b_q <= '0;
         cap_c_q <= '0;
         cap_d_q <= '0;
      end else begin
         if (cap_evt[0]) cap_a_q <= cnt_q;
         if (cap_evt[1]) cap_b_q <= cnt_q;
         if (cap_evt[3]) cap_d_q <= cnt_q;
         if (buf_on) begin
            if (cap_evt[0]) cap_c_q <= cap_a_q;
         end else if (cap_evt[2]) begin
            cap_c_q <= cnt_q;
         end
      end
   end

   always_comb begin
      unique case (cpu_addr_i)
         A_STS:   cpu_rdata_o = {{PAD_W{1'b0}}, sts_q};
         A_CNT:   cpu_rdata_o = cnt_q;
         A_CMPA:  cpu_rdata_o = cmp_a_q;
         A_CMPB:  cpu_rdata_o = cmp_b_q;
         A_CAPA:  cpu_rdata_o = cap_a_q;
         A_CAPB:  cpu_rdata_o = cap_b_q;
         A_CAPC:  cpu_rdata_o = cap_c_q;
         default: cpu_rdata_o = cap_d_q;
      endcase
   end

   assign ovf_irq_o = sts_q[B_OVF] & ovf_ie_i;
endmodule

// File: rtl/tmr_evt_unit_chk.sv
module tmr_evt_unit_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             stby_i,
   input logic             tick_i,
   input logic             ovf_ie_i,
   input logic             ovf_irq_o,
   input logic             cpu_sel_i,
   input logic             cpu_wr_i,
   input logic [2:0]       cpu_addr_i,
   input logic [7:0]       sts_q,
   input logic [7:1]       set_vec,
   input logic [3:0]       cap_evt,
   input logic [CNT_W-1:0] cnt_q,
   input logic [CNT_W-1:0] cmp_a_q
);
   logic sts_wr, cnt_wr;
   assign sts_wr = cpu_sel_i && cpu_wr_i && (cpu_addr_i == 3'd0);
   assign cnt_wr = cpu_sel_i && cpu_wr_i && (cpu_addr_i == 3'd1);

   // R2: a flag rises only after a hardware event for that bit
   assert_flag_rise_hw_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((sts_q[7:1] & ~$past(sts_q[7:1]) & ~$past(set_vec)) == 7'd0));

   // R3: a flag falls only after a status write or standby
   assert_flag_fall_wr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(sts_q[7:1]) & ~sts_q[7:1]) != 7'd0) |-> $past(sts_wr || stby_i));

   // R5: standby empties the status word
   assert_stby_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      stby_i |=> (sts_q == 8'h00));

   // R9: a synchronized capture event lasts one cycle
   assert_cap_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_evt != 4'd0) |=> ((cap_evt & $past(cap_evt)) == 4'd0));

   // R11: compare-A clear loads zero
   assert_cclr_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !cnt_wr && sts_q[0] && cnt_q == cmp_a_q) |=> (cnt_q == '0));

   // R13: request masked by the enable, and needs the flag
   assert_irq_mask_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !ovf_ie_i |-> !ovf_irq_o);
   assert_irq_flag_R13: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_irq_o |-> sts_q[1]);
endmodule

bind tmr_evt_unit tmr_evt_unit_chk #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .stby_i     (stby_i),
   .tick_i     (tick_i),
   .ovf_ie_i   (ovf_ie_i),
   .ovf_irq_o  (ovf_irq_o),
   .cpu_sel_i  (cpu_sel_i),
   .cpu_wr_i   (cpu_wr_i),
   .cpu_addr_i (cpu_addr_i),
   .sts_q      (sts_q),
   .set_vec    (set_vec),
   .cap_evt    (cap_evt),
   .cnt_q      (cnt_q),
   .cmp_a_q    (cmp_a_q)
);

// File: tb/tmr_evt_unit_tb.sv
`timescale 1ns/1ps
module tmr_evt_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        stby = 1'b0, tick = 1'b0, buf_a = 1'b0, ovf_ie = 1'b0;
   logic [3:0]  cap = 4'd0;
   logic        sel = 1'b0, wr = 1'b0;
   logic [2:0]  addr = 3'd0;
   logic [15:0] wdata = 16'd0;
   logic [15:0] rdata;
   logic        irq;
   int          checks = 0, errors = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   tmr_evt_unit u_dut (
      .clk(clk), .rst_n(rst_n), .stby_i(stby), .tick_i(tick), .cap_i(cap),
      .buf_a_i(buf_a), .ovf_ie_i(ovf_ie), .cpu_sel_i(sel), .cpu_wr_i(wr),
      .cpu_addr_i(addr), .cpu_wdata_i(wdata), .cpu_rdata_o(rdata),
      .ovf_irq_o(irq)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      sel = 1'b0; wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [2:0] a, output logic [15:0] d);
      @(negedge clk);
      sel = 1'b1; wr = 1'b0; addr = a;
      #0.5 d = rdata;
      @(negedge clk);
      sel = 1'b0;
   endtask

   task automatic run_ticks(input int n);
      @(negedge clk);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic pulse_cap(input int ch);
      @(negedge clk);
      cap[ch] = 1'b1;
      repeat (6) @(negedge clk);
      cap[ch] = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic clear_all();
      logic [15:0] t;
      rd_reg(3'd0, t);
      wr_reg(3'd0, 16'h0000);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [15:0] v, v1, v2;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state of all registers
      for (int a = 0; a < 8; a++) begin
         rd_reg(3'(a), v);
         chk("R1 reset value", v, 16'h0000);
      end
      chk("R1 irq low", {15'd0, irq}, 16'h0000);

      // R2: flag bits not software-settable, bit 0 read/write
      wr_reg(3'd0, 16'h00FF);
      rd_reg(3'd0, v); chk("R2 ones write", v, 16'h0001);
      wr_reg(3'd0, 16'h0000);
      rd_reg(3'd0, v); chk("R2 bit0 clear", v, 16'h0000);

      // R14: load and tick
      wr_reg(3'd1, 16'h1234);
      rd_reg(3'd1, v); chk("R14 load", v, 16'h1234);
      run_ticks(10);
      rd_reg(3'd1, v); chk("R14 ten ticks", v, 16'h123E);

      // R6: capture A sweep, buffered mode off
      for (int i = 0; i < 16; i++) begin
         v1 = 16'(i * 16'h1357 + 16'h0101);
         wr_reg(3'd1, v1);
         pulse_cap(0);
         rd_reg(3'd4, v); chk("R6 capture A value", v, v1);
         rd_reg(3'd0, v); chk("R6 flag bit7", v & 16'h0080, 16'h0080);
      end
      rd_reg(3'd6, v); chk("R6 capture C untouched", v, 16'h0000);

      // R3: clearing needs a prior read
      wr_reg(3'd0, 16'h00FE);           // drops arming, clears nothing
      wr_reg(3'd0, 16'h0000);           // not armed: flag stays
      rd_reg(3'd0, v); chk("R3 unarmed write keeps flag", v & 16'h0080, 16'h0080);
      wr_reg(3'd0, 16'h0000);
      rd_reg(3'd0, v); chk("R3 armed write clears", v, 16'h0000);

      // R7: buffered capture A
      buf_a = 1'b1;
      v1 = 16'hA5A5; v2 = 16'h5A5A;
      wr_reg(3'd1, v1); pulse_cap(0);
      wr_reg(3'd1, v2); pulse_cap(0);
      rd_reg(3'd4, v); chk("R7 new value in A", v, v2);
      rd_reg(3'd6, v); chk("R7 old value in C", v, v1);

      // R8: channels B, C, D
      clear_all();
      wr_reg(3'd1, 16'h0C0C); pulse_cap(2);
      rd_reg(3'd6, v); chk("R8 C not loaded in buffered mode", v, v1);
      rd_reg(3'd0, v); chk("R8 flag bit5", v, 16'h0020);
      buf_a = 1'b0;
      wr_reg(3'd1, 16'h0B0B); pulse_cap(1);
      wr_reg(3'd1, 16'h0C1C); pulse_cap(2);
      wr_reg(3'd1, 16'h0D0D); pulse_cap(3);
      rd_reg(3'd5, v); chk("R8 capture B", v, 16'h0B0B);
      rd_reg(3'd6, v); chk("R8 capture C", v, 16'h0C1C);
      rd_reg(3'd7, v); chk("R8 capture D", v, 16'h0D0D);
      rd_reg(3'd0, v); chk("R8 flags 6..4", v, 16'h0070);

      // R9: held input captures once
      clear_all();
      wr_reg(3'd1, 16'h0AAA);
      @(negedge clk); cap[1] = 1'b1;
      repeat (6) @(negedge clk);
      rd_reg(3'd5, v); chk("R9 first capture", v, 16'h0AAA);
      wr_reg(3'd1, 16'h0BBB);
      repeat (6) @(negedge clk);
      rd_reg(3'd5, v); chk("R9 no recapture while high", v, 16'h0AAA);
      clear_all();
      repeat (6) @(negedge clk);
      rd_reg(3'd0, v); chk("R9 flag not re-set while high", v, 16'h0000);
      cap[1] = 1'b0;
      repeat (6) @(negedge clk);

      // R10: compare flags
      wr_reg(3'd2, 16'h0010);
      wr_reg(3'd3, 16'h0020);
      wr_reg(3'd1, 16'h0008);
      run_ticks(8);
      rd_reg(3'd0, v); chk("R10 before match", v, 16'h0000);
      run_ticks(1);
      rd_reg(3'd0, v); chk("R10 compare A flag", v, 16'h0008);
      run_ticks(16);
      rd_reg(3'd0, v); chk("R10 compare B flag", v, 16'h000C);

      // R11: clear on compare A, stepwise sweep
      wr_reg(3'd2, 16'h0005);
      wr_reg(3'd1, 16'h0000);
      clear_all();
      wr_reg(3'd0, 16'h0001);
      for (int k = 1; k <= 13; k++) begin
         run_ticks(1);
         rd_reg(3'd1, v);
         chk("R11 modulo count", v, 16'(k % 6));
      end
      run_ticks(23);
      rd_reg(3'd1, v); chk("R11 long run", v, 16'(((13 + 23) % 6)));
      clear_all();
      wr_reg(3'd1, 16'h0000);
      run_ticks(9);
      rd_reg(3'd1, v); chk("R11 free run when off", v, 16'h0009);

      // R12 / R13: overflow and interrupt
      clear_all();
      wr_reg(3'd1, 16'hFFFD);
      run_ticks(2);
      rd_reg(3'd0, v); chk("R12 no flag before wrap", v & 16'h0002, 16'h0000);
      run_ticks(3);
      rd_reg(3'd1, v); chk("R12 wrapped count", v, 16'h0002);
      rd_reg(3'd0, v); chk("R12 overflow flag", v & 16'h0002, 16'h0002);
      #0.5 chk("R13 masked", {15'd0, irq}, 16'h0000);
      ovf_ie = 1'b1;
      #0.5 chk("R13 raised", {15'd0, irq}, 16'h0001);
      clear_all();
      #0.5 chk("R13 dropped after clear", {15'd0, irq}, 16'h0000);

      // R4: set wins over clear in the same cycle
      clear_all();
      wr_reg(3'd2, 16'h0030);
      wr_reg(3'd3, 16'h0031);
      wr_reg(3'd1, 16'h0030);
      run_ticks(2);
      wr_reg(3'd1, 16'h0030);
      rd_reg(3'd0, v); chk("R4 setup flags", v, 16'h000C);
      sel = 1'b1; wr = 1'b1; addr = 3'd0; wdata = 16'h0000; tick = 1'b1;
      @(negedge clk);
      sel = 1'b0; wr = 1'b0; tick = 1'b0;
      rd_reg(3'd0, v); chk("R4 set wins, other clears", v, 16'h0008);

      // R5: standby empties status
      wr_reg(3'd0, 16'h0001);
      @(negedge clk); stby = 1'b1;
      @(negedge clk); stby = 1'b0;
      rd_reg(3'd0, v); chk("R5 standby clears", v, 16'h0000);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule